// File: doc/BRIEF.md
# E1 Transmit Line Encoder

This block is the transmit-side front end of one E1 line-interface channel. It samples terminal data on a chosen edge of the 2.048 MHz transmit clock. It produces two registered rail outputs, one for positive line pulses and one for negative line pulses, which feed the line driver. In single-rail mode one serial data bit is taken per clock and turned into alternate-mark-inversion pulses. When zero substitution is enabled, every run of four zeros is replaced by a pattern that carries a deliberate polarity violation. This guarantees pulse density for clock recovery at the far end.

In dual-rail mode the terminal supplies already-encoded positive and negative rails, and these pass straight through. A remote-loopback enable takes priority over both modes and sends received dual-rail data back out on the transmit rails. The zero-run length is a parameter, `RUN_LEN`. Its default of 4 gives standard HDB3.

Top module: `e1_tx_encoder`

## Requirements
- R1: A synchronous active-high `srst` clears the encoder state. Any active edge taken with `srst` high leaves `pdata` and `ndata` both low.
- R2: With `tclk_inv` = 0 all inputs are sampled and outputs updated on the falling edge of `tclk`. With `tclk_inv` = 1 this happens on the rising edge. The select applies in single-rail, dual-rail and loopback operation alike.
- R3: In single-rail mode (`dual_rail` = 0) the `tneg` input has no effect on the outputs.
- R4: In single-rail mode the symbol for a data bit sampled at active edge k is presented on the rails after active edge k+4. The four delay stages hold zeros when reset is released.
- R5: In single-rail mode a mark is a pulse on exactly one rail: `pdata`=1 for positive, `ndata`=1 for negative. A zero drives both rails low, and the two rails are never high together. Ordinary marks alternate in polarity. The first mark after reset is positive.
- R6: With `code_en` = 1 in single-rail mode, each run of four zeros not already part of a substitution is replaced. If the number of pulses since the last violation is odd, the replacement is 000V. If that number is even, the replacement is B00V. B takes the polarity opposite the previous pulse. V repeats the polarity of the previous pulse. The pulse count is cleared at each V and at reset.
- R7: With `code_en` = 0 in single-rail mode, ones are sent as plain alternating marks and zero runs of any length stay zero.
- R8: With `dual_rail` = 1 and loopback off, `pdata`/`ndata` equal the `tpos`/`tneg` values sampled at the previous active edge, unchanged and independent of `code_en`. Both rails may be high together.
- R9: With `lb_en` = 1, `pdata`/`ndata` equal `lb_p`/`lb_n` from the previous active edge, in either rail mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | 2.048 MHz transmit clock |
| tclk_inv | input | 1 | 0: sample on falling edge, 1: sample on rising edge |
| srst | input | 1 | Synchronous active-high reset |
| dual_rail | input | 1 | 1: pre-encoded rails pass through, 0: single-rail data |
| code_en | input | 1 | Enables four-zero substitution in single-rail mode |
| tpos | input | 1 | Single-rail data, or positive rail in dual-rail mode |
| tneg | input | 1 | Negative rail in dual-rail mode |
| lb_en | input | 1 | Remote loopback select |
| lb_p | input | 1 | Received positive rail for loopback |
| lb_n | input | 1 | Received negative rail for loopback |
| pdata | output | 1 | Registered positive-pulse rail |
| ndata | output | 1 | Registered negative-pulse rail |

## Verification
The bench builds the block only with the default `RUN_LEN` = 4, the HDB3 case. At that size a 32-bit pattern holds several zero runs back to back, so both the 000V and the B00V choices are reached. Each pattern is preceded by the four reset zeros, so the substitution on the empty delay line right after reset is also reached. Long all-ones and all-zeros stretches show mark alternation and the violation-to-violation parity within a few dozen cycles. Both sampling edges are used, and the edge choice is checked by observing the rails between the two edges of one clock period.

// File: rtl/e1_tx_encoder.sv
module e1_tx_encoder #(
  parameter int RUN_LEN = 4
) (
  input  logic tclk,
  input  logic tclk_inv,
  input  logic srst,
  input  logic dual_rail,
  input  logic code_en,
  input  logic tpos,
  input  logic tneg,
  input  logic lb_en,
  input  logic lb_p,
  input  logic lb_n,
  output logic pdata,
  output logic ndata
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;

  logic          sclk;
  logic [RUN_LEN-1:0] dly;
  logic [CW-1:0] sub_cnt;
  logic          last_pos;
  logic          par_odd;

  assign sclk = tclk_inv ? tclk : ~tclk;

  // dly[RUN_LEN-1] is the next bit to leave the line
  logic head, start, in_sub, is_v, is_b, mark, pulse, pol_pos;
  assign head    = dly[RUN_LEN-1];
  assign start   = code_en && (sub_cnt == '0) && (dly == '0);
  assign in_sub  = code_en && (sub_cnt != '0);
  assign is_v    = in_sub && (sub_cnt == CW'(1));
  assign is_b    = start && !par_odd;
  assign mark    = is_b || (!start && !in_sub && head);
  assign pulse   = mark || is_v;
  assign pol_pos = is_v ? last_pos : ~last_pos;

  logic enc_p, enc_n;
  assign enc_p = pulse && pol_pos;
  assign enc_n = pulse && !pol_pos;

  always_ff @(posedge sclk) begin
    if (srst) begin
      dly      <= '0;
      sub_cnt  <= '0;
      last_pos <= 1'b0;
      par_odd  <= 1'b0;
      pdata    <= 1'b0;
      ndata    <= 1'b0;
    end else begin
      if (!dual_rail) begin
        dly <= {dly[RUN_LEN-2:0], tpos};
        if (start)       sub_cnt <= CW'(RUN_LEN - 1);
        else if (in_sub) sub_cnt <= sub_cnt - CW'(1);
        else             sub_cnt <= '0;
        if (pulse) last_pos <= pol_pos;
        if (is_v)       par_odd <= 1'b0;
        else if (mark)  par_odd <= ~par_odd;
      end
      if (lb_en) begin
        pdata <= lb_p;
        ndata <= lb_n;
      end else if (dual_rail) begin
        pdata <= tpos;
        ndata <= tneg;
      end else begin
        pdata <= enc_p;
        ndata <= enc_n;
      end
    end
  end
endmodule

// File: rtl/e1_tx_encoder_chk.sv
module e1_tx_encoder_chk (
  input logic tclk,
  input logic tclk_inv,
  input logic srst,
  input logic dual_rail,
  input logic tpos,
  input logic tneg,
  input logic lb_en,
  input logic lb_p,
  input logic lb_n,
  input logic pdata,
  input logic ndata
);
  logic sclk;
  assign sclk = tclk_inv ? tclk : ~tclk;

  AST_RESET_CLEARS: assert property (@(posedge sclk) disable iff (srst)
    $fell(srst) |-> (!pdata && !ndata)); // R1

  AST_SINGLE_EXCLUSIVE: assert property (@(posedge sclk) disable iff (srst)
    (!dual_rail && !lb_en) |=> !(pdata && ndata)); // R5

  AST_DUAL_PASS: assert property (@(posedge sclk) disable iff (srst)
    (dual_rail && !lb_en) |=> (pdata == $past(tpos) && ndata == $past(tneg))); // R8

  AST_LOOP_SELECT: assert property (@(posedge sclk) disable iff (srst)
    lb_en |=> (pdata == $past(lb_p) && ndata == $past(lb_n))); // R9
endmodule

bind e1_tx_encoder e1_tx_encoder_chk u_chk (
  .tclk(tclk), .tclk_inv(tclk_inv), .srst(srst), .dual_rail(dual_rail),
  .tpos(tpos), .tneg(tneg), .lb_en(lb_en), .lb_p(lb_p), .lb_n(lb_n),
  .pdata(pdata), .ndata(ndata)
);

// File: tb/test_e1_tx_encoder.sv
module test_e1_tx_encoder;
  logic tclk = 1'b0;
  logic tclk_inv = 1'b0, srst = 1'b1, dual_rail = 1'b0, code_en = 1'b0;
  logic tpos = 1'b0, tneg = 1'b0, lb_en = 1'b0, lb_p = 1'b0, lb_n = 1'b0;
  logic pdata, ndata;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #10 tclk = ~tclk;

  e1_tx_encoder i_e1_tx_encoder (
    .tclk(tclk), .tclk_inv(tclk_inv), .srst(srst), .dual_rail(dual_rail),
    .code_en(code_en), .tpos(tpos), .tneg(tneg), .lb_en(lb_en),
    .lb_p(lb_p), .lb_n(lb_n), .pdata(pdata), .ndata(ndata)
  );

  // {tclk_inv, code_en, pattern (bit 0 first)}
  localparam logic [33:0] VEC [7] = '{
    {1'b0, 1'b1, 32'h0000_0000},
    {1'b0, 1'b1, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'h1001_0001},
    {1'b0, 1'b1, 32'h0F00_F0A5},
    {1'b0, 1'b0, 32'h1001_0001},
    {1'b0, 1'b1, 32'h8000_0001},
    {1'b1, 1'b1, 32'h0F00_F0A5}
  };

  logic [1:0] exp_sym [44];

  task automatic cyc();
    @(posedge tclk);
    #5;
  endtask

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Line-code reference: P = 2'b10, N = 2'b01, zero = 2'b00
  task automatic build(input logic code, input logic [31:0] pat);
    logic s [44];
    logic lastp = 1'b0;
    logic odd = 1'b0;
    int i = 0;
    for (int j = 0; j < 44; j++) s[j] = (j >= 4 && j < 36) ? pat[j-4] : 1'b0;
    while (i < 44) begin
      if (code && i + 3 < 44 && !s[i] && !s[i+1] && !s[i+2] && !s[i+3]) begin
        if (odd) exp_sym[i] = 2'b00;
        else begin
          lastp = ~lastp;
          exp_sym[i] = lastp ? 2'b10 : 2'b01;
        end
        exp_sym[i+1] = 2'b00;
        exp_sym[i+2] = 2'b00;
        exp_sym[i+3] = lastp ? 2'b10 : 2'b01;
        odd = 1'b0;
        i += 4;
      end else begin
        if (s[i]) begin
          lastp = ~lastp;
          odd = ~odd;
          exp_sym[i] = lastp ? 2'b10 : 2'b01;
        end else exp_sym[i] = 2'b00;
        i++;
      end
    end
  endtask

  task automatic do_reset(input logic inv, input logic dual, input logic code);
    srst = 1'b1;
    tclk_inv = inv;
    dual_rail = dual;
    code_en = code;
    lb_en = 1'b0; lb_p = 1'b0; lb_n = 1'b0;
    tpos = 1'b0; tneg = 1'b0;
    cyc(); cyc(); cyc();
    srst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    cyc();
    // R1: drive rails high in dual mode, then reset
    do_reset(1'b0, 1'b1, 1'b0);
    tpos = 1'b1; tneg = 1'b1;
    cyc();
    chk({pdata, ndata}, 2'b11, "R8 both rails pass");
    srst = 1'b1;
    cyc();
    chk({pdata, ndata}, 2'b00, "R1 reset clears rails");
    srst = 1'b0;

    // Table: R3 R4 R5 R6 R7 (tneg driven opposite to data)
    for (int r = 0; r < 7; r++) begin
      logic [31:0] pat;
      pat = VEC[r][31:0];
      do_reset(VEC[r][33], 1'b0, VEC[r][32]);
      build(VEC[r][32], pat);
      for (int k = 1; k <= 40; k++) begin
        tpos = (k - 1 < 32) ? pat[k-1] : 1'b0;
        tneg = ~tpos;
        cyc();
        chk({pdata, ndata}, exp_sym[k-1],
            $sformatf("R3/R4/R5/R6/R7 row %0d symbol %0d", r, k - 1));
      end
    end

    // R2: rising-edge sampling, observe between edges
    do_reset(1'b1, 1'b1, 1'b0);
    cyc();
    tpos = 1'b1; tneg = 1'b0;
    #10;
    chk({pdata, ndata}, 2'b00, "R2 inv=1 no update on falling edge");
    #10;
    chk({pdata, ndata}, 2'b10, "R2 inv=1 update on rising edge");
    // R2: falling-edge sampling
    do_reset(1'b0, 1'b1, 1'b0);
    cyc();
    tpos = 1'b0; tneg = 1'b1;
    #10;
    chk({pdata, ndata}, 2'b01, "R2 inv=0 update on falling edge");
    tpos = 1'b1;
    #10;
    chk({pdata, ndata}, 2'b01, "R2 inv=0 no update on rising edge");
    cyc();
    chk({pdata, ndata}, 2'b11, "R8 dual rail both high");

    // R8: dual rail ignores code_en
    code_en = 1'b1;
    tpos = 1'b0; tneg = 1'b0;
    cyc(); cyc(); cyc(); cyc(); cyc();
    chk({pdata, ndata}, 2'b00, "R8 zeros not substituted in dual rail");

    // R9: loopback in single-rail and dual-rail
    do_reset(1'b0, 1'b0, 1'b1);
    lb_en = 1'b1; lb_p = 1'b0; lb_n = 1'b1;
    cyc();
    chk({pdata, ndata}, 2'b01, "R9 loopback single-rail");
    lb_p = 1'b1; lb_n = 1'b1;
    cyc();
    chk({pdata, ndata}, 2'b11, "R9 loopback both rails");
    dual_rail = 1'b1; tpos = 1'b1; tneg = 1'b0; lb_p = 1'b0; lb_n = 1'b1;
    cyc();
    chk({pdata, ndata}, 2'b01, "R9 loopback overrides dual rail");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule